// File: doc/BRIEF.md
# I2C Interrupt Status Controller

This block gathers the event pulses produced by the master and slave engines of an I2C port and turns them into one interrupt request line. Each of the two sources has a raw status bit, a software enable bit and a masked status bit. A raw bit latches on every event, whether or not its enable is set. A pending bit is cleared by writing 1 to its position in a write-one-to-clear register. The request line is high while either source is both pending and enabled.

For the master side, the block also keeps the result of the last transaction: an error flag plus the two possible causes, a missing acknowledge and a lost arbitration. Software reads this result after each master interrupt. A small state machine tracks the master transaction.

The state machine has four states:
- `ST_IDLE`: no transaction has been seen since reset.
- `ST_BUSY`: a transaction is running.
- `ST_END_OK`: the last transaction ended cleanly.
- `ST_END_ERR`: the last transaction ended with a fault.

Its transitions are:
- `ST_IDLE` moves to `ST_BUSY` on a start pulse.
- Any state moves to `ST_END_OK` on an end pulse that carries no fault.
- Any state moves to `ST_END_ERR` on an end pulse that carries a fault.
- `ST_END_OK` and `ST_END_ERR` move to `ST_BUSY` on a start pulse.
- In every other case the state is held.

The register port is a single-cycle write strobe with a combinational read of the addressed register.

Top module: `i2c_irq_hub`

## Requirements
- R1: After reset, every raw, enable and result bit reads 0 and `irq_o` is low.
- R2: A pulse on `m_done_i`, `m_nack_i` or `m_arb_lost_i` (a master transaction end) sets the master raw bit, which is bit 0 of the raw register at address 1.
- R3: A pulse on `s_rx_i` or `s_req_i` sets the slave raw bit, which is bit 1 of the raw register at address 1.
- R4: Address 0 is the enable register: bit 0 enables the master source and bit 1 enables the slave source. It is written whole and reads back what was written. With an enable at 0, the raw bit still latches but it does not drive `irq_o`.
- R5: `irq_o` equals (master raw AND master enable) OR (slave raw AND slave enable). It follows the status registers combinationally.
- R6: Writing to address 3 clears each raw bit whose data bit is 1 (bit 0 is master, bit 1 is slave). A 0 leaves that raw bit unchanged. Address 3 reads 0.
- R7: An event in the same cycle as a clear of its own source leaves the raw bit set.
- R8: At address 4, bit 0 is the error flag, bit 1 is the missing-acknowledge cause and bit 2 is the lost-arbitration cause. At each transaction end these take the values of that end: the error flag is set if either cause is present, and all three are 0 after a clean `m_done_i`.
- R9: The result at address 4 holds until a `m_start_i` pulse, which clears all three bits. If a start and an end arrive in the same cycle, the end is recorded.
- R10: Address 2 reads the masked status: raw AND enable, per bit. Writes to addresses other than 0 and 3 change nothing, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_start_i | input | 1 | Master transaction start pulse |
| m_done_i | input | 1 | Master transaction completed cleanly (transmit or receive) |
| m_nack_i | input | 1 | Master transaction ended: target did not acknowledge |
| m_arb_lost_i | input | 1 | Master transaction ended: arbitration lost |
| s_rx_i | input | 1 | Slave received data pulse |
| s_req_i | input | 1 | Slave data requested by remote master pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address for read and write |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after these corner cases:
- **Event and clear in the same cycle.** A design that let the clear win would drop an interrupt.
- **Clear with a data bit of 0, and a clear of one side only.** A design that cleared the whole register would lose the other source's pending bit.
- **Events arriving while the enable is 0.** A design that gated latching with the enable would never raise the line once the source is enabled.
- **The master result across a clean end, each fault cause, a start, and a start that coincides with an end.** A design that cleared the result at the interrupt clear, or let the start win, would report a stale or missing cause.

// File: rtl/i2c_irq_pkg.sv
`timescale 1ns/1ps
package i2c_irq_pkg;
    localparam int NUM_SRC    = 2;
    localparam int SRC_MASTER = 0;
    localparam int SRC_SLAVE  = 1;

    localparam int RA_ENABLE = 0;
    localparam int RA_RAW    = 1;
    localparam int RA_MASKED = 2;
    localparam int RA_CLEAR  = 3;
    localparam int RA_RESULT = 4;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_END_OK  = 2'd2,
        ST_END_ERR = 2'd3
    } mst_state_e;

    typedef struct packed {
        logic arb;
        logic nack;
        logic err;
    } mst_result_t;
endpackage

// File: rtl/irq_src_cell.sv
`timescale 1ns/1ps
module irq_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic en_we_i,
    input  logic en_d_i,
    input  logic clr_i,
    output logic raw_o,
    output logic en_o,
    output logic pend_o
);
    logic raw_q;
    logic en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (evt_i) begin
            raw_q <= 1'b1;
        end else if (clr_i) begin
            raw_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (en_we_i) begin
            en_q <= en_d_i;
        end
    end

    assign raw_o  = raw_q;
    assign en_o   = en_q;
    assign pend_o = raw_q & en_q;

    a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> raw_o)
        else $error("R7: event did not leave raw bit set");

    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !evt_i) |=> !raw_o)
        else $error("R6: clear did not drop raw bit");

    a_r6_raw_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !evt_i) |=> $stable(raw_o))
        else $error("R6: raw bit changed without cause");

    a_r4_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we_i |=> $stable(en_o))
        else $error("R4: enable changed without write");
endmodule

// File: rtl/mst_result_fsm.sv
`timescale 1ns/1ps
module mst_result_fsm
    import i2c_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        done_i,
    input  logic        nack_i,
    input  logic        arb_i,
    output logic        end_o,
    output mst_result_t result_o
);
    mst_state_e state_q, state_d;
    logic nack_q, arb_q;
    logic fault;

    assign end_o = done_i | nack_i | arb_i;
    assign fault = nack_i | arb_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_BUSY, ST_END_OK, ST_END_ERR: begin
                if (end_o) begin
                    state_d = fault ? ST_END_ERR : ST_END_OK;
                end else if (start_i) begin
                    state_d = ST_BUSY;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nack_q  <= 1'b0;
            arb_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (end_o) begin
                nack_q <= nack_i;
                arb_q  <= arb_i;
            end else if (start_i) begin
                nack_q <= 1'b0;
                arb_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        result_o = '0;
        unique case (state_q)
            ST_IDLE, ST_BUSY, ST_END_OK: result_o.err = 1'b0;
            ST_END_ERR:                  result_o.err = 1'b1;
        endcase
        result_o.nack = nack_q;
        result_o.arb  = arb_q;
    end

    a_r8_fault_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_i || arb_i) |=> result_o.err)
        else $error("R8: fault end without error flag");

    a_r8_clean_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !nack_i && !arb_i) |=> (result_o == '0))
        else $error("R8: clean end left result bits");

    a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !end_o) |=> (state_q == ST_BUSY && result_o == '0))
        else $error("R9: start did not clear result");

    a_r9_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !end_o) |=> $stable(result_o))
        else $error("R9: result changed without cause");
endmodule

// File: rtl/i2c_irq_hub.sv
`timescale 1ns/1ps
module i2c_irq_hub
    import i2c_irq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_start_i,
    input  logic              m_done_i,
    input  logic              m_nack_i,
    input  logic              m_arb_lost_i,
    input  logic              s_rx_i,
    input  logic              s_req_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    localparam int RES_W = $bits(mst_result_t);

    logic [NUM_SRC-1:0] evt, raw, en, pend, clr;
    logic               en_we;
    logic               m_end;
    mst_result_t        m_res;

    mst_result_fsm u_mres (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (m_start_i),
        .done_i   (m_done_i),
        .nack_i   (m_nack_i),
        .arb_i    (m_arb_lost_i),
        .end_o    (m_end),
        .result_o (m_res)
    );

    assign evt[SRC_MASTER] = m_end;
    assign evt[SRC_SLAVE]  = s_rx_i | s_req_i;

    assign en_we = reg_wr_i && (reg_addr_i == ADDR_W'(RA_ENABLE));
    assign clr   = (reg_wr_i && (reg_addr_i == ADDR_W'(RA_CLEAR)))
                 ? reg_wdata_i[NUM_SRC-1:0] : '0;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_i   (evt[g]),
            .en_we_i (en_we),
            .en_d_i  (reg_wdata_i[g]),
            .clr_i   (clr[g]),
            .raw_o   (raw[g]),
            .en_o    (en[g]),
            .pend_o  (pend[g])
        );
    end

    assign irq_o = |pend;

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == ADDR_W'(RA_ENABLE)) begin
            reg_rdata_o[NUM_SRC-1:0] = en;
        end else if (reg_addr_i == ADDR_W'(RA_RAW)) begin
            reg_rdata_o[NUM_SRC-1:0] = raw;
        end else if (reg_addr_i == ADDR_W'(RA_MASKED)) begin
            reg_rdata_o[NUM_SRC-1:0] = pend;
        end else if (reg_addr_i == ADDR_W'(RA_RESULT)) begin
            reg_rdata_o[RES_W-1:0] = m_res;
        end
    end

    a_r5_line_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw[SRC_MASTER] && en[SRC_MASTER]) || (raw[SRC_SLAVE] && en[SRC_SLAVE])))
        else $error("R5: request line high with nothing pending");

    a_r2_master_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done_i || m_nack_i || m_arb_lost_i) |=> raw[SRC_MASTER])
        else $error("R2: master end did not latch");

    a_r3_slave_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rx_i || s_req_i) |=> raw[SRC_SLAVE])
        else $error("R3: slave event did not latch");
endmodule

// File: tb/i2c_irq_hub_bench.sv
`timescale 1ns/1ps
module i2c_irq_hub_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_start = 0, m_done = 0, m_nack = 0, m_arb = 0, s_rx = 0, s_req = 0;
    logic       reg_wr = 0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    string scen = "R1";

    // reference model state
    bit mr, sr, me, se, er, nk, ab;

    i2c_irq_hub u_i2c_irq_hub (
        .clk(clk), .rst_n(rst_n),
        .m_start_i(m_start), .m_done_i(m_done), .m_nack_i(m_nack),
        .m_arb_lost_i(m_arb), .s_rx_i(s_rx), .s_req_i(s_req),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog expired: actual=%0d cycles expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [7:0] exp_rd(input int a);
        case (a)
            0: return {6'd0, se, me};
            1: return {6'd0, sr, mr};
            2: return {6'd0, sr & se, mr & me};
            4: return {5'd0, ab, nk, er};
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s): actual=%h expected=%h", tag, scen, act, exp);
        end
    endtask

    task automatic compare_all();
        reg_wr = 0; m_start = 0; m_done = 0; m_nack = 0; m_arb = 0; s_rx = 0; s_req = 0;
        for (int a = 0; a < 6; a++) begin
            reg_addr = 3'(a);
            #0.1;
            case (a)
                0: chk("R4 enable reg", reg_rdata, exp_rd(a));
                1: chk("R2/R3 raw reg", reg_rdata, exp_rd(a));
                2: chk("R10 masked reg", reg_rdata, exp_rd(a));
                3: chk("R6 clear reads 0", reg_rdata, exp_rd(a));
                4: chk("R8 result reg", reg_rdata, exp_rd(a));
                default: chk("R10 unused reads 0", reg_rdata, exp_rd(a));
            endcase
        end
        chk("R5 irq line", {7'd0, irq}, {7'd0, (mr & me) | (sr & se)});
    endtask

    // ev bits: {s_req, s_rx, m_arb, m_nack, m_done, m_start}
    task automatic cyc(input bit wr, input int a, input logic [7:0] d, input logic [5:0] ev);
        bit mend, sev;
        reg_wr = wr; reg_addr = 3'(a); reg_wdata = d;
        {s_req, s_rx, m_arb, m_nack, m_done, m_start} = ev;
        @(posedge clk);
        mend = ev[1] | ev[2] | ev[3];
        sev  = ev[4] | ev[5];
        if (mend) mr = 1; else if (wr && a == 3 && d[0]) mr = 0;
        if (sev)  sr = 1; else if (wr && a == 3 && d[1]) sr = 0;
        if (wr && a == 0) begin me = d[0]; se = d[1]; end
        if (mend) begin er = ev[2] | ev[3]; nk = ev[2]; ab = ev[3]; end
        else if (ev[0]) begin er = 0; nk = 0; ab = 0; end
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        scen = "R1 reset";
        compare_all();
        cyc(0, 0, 0, 0);

        scen = "R2 done with mask 0 (R4)";
        cyc(0, 0, 0, 6'b000010);
        scen = "R4 enable master";
        cyc(1, 0, 8'h01, 0);
        scen = "R6 clear with zero data";
        cyc(1, 3, 8'h00, 0);
        scen = "R6 clear master";
        cyc(1, 3, 8'h01, 0);

        scen = "R3 slave rx";
        cyc(0, 0, 0, 6'b010000);
        scen = "R4 enable slave only";
        cyc(1, 0, 8'h02, 0);
        scen = "R2 nack end while master disabled";
        cyc(0, 0, 0, 6'b000100);
        scen = "R6 clear slave only";
        cyc(1, 3, 8'h02, 0);
        scen = "R3 slave request";
        cyc(0, 0, 0, 6'b100000);
        scen = "R10 write to result/unused addresses";
        cyc(1, 4, 8'hFF, 0);
        cyc(1, 5, 8'hFF, 0);
        cyc(1, 1, 8'hFF, 0);
        scen = "R7 event with clear same cycle";
        cyc(1, 0, 8'h03, 0);
        cyc(1, 3, 8'h03, 6'b100010);
        cyc(1, 3, 8'h03, 6'b000010);
        cyc(1, 3, 8'h03, 0);

        scen = "R9 start clears result";
        cyc(0, 0, 0, 6'b000001);
        scen = "R8 arbitration lost";
        cyc(0, 0, 0, 6'b001000);
        scen = "R9 result held across clear";
        cyc(1, 3, 8'h03, 0);
        cyc(0, 0, 0, 0);
        scen = "R9 start clears result";
        cyc(0, 0, 0, 6'b000001);
        scen = "R8 clean done";
        cyc(0, 0, 0, 6'b000010);
        scen = "R9 start and nack same cycle";
        cyc(0, 0, 0, 6'b000101);
        scen = "R8 both causes";
        cyc(0, 0, 0, 6'b001100);
        scen = "R9 start then done same cycle";
        cyc(0, 0, 0, 6'b000011);
        scen = "R5 mixed traffic";
        for (int i = 0; i < 40; i++) begin
            cyc((i % 3) == 0, (i % 2) ? 3 : 0, 8'(i * 7), 6'((i * 13) % 64));
        end

        scen = "R1 reset mid-run";
        rst_n = 0;
        mr = 0; sr = 0; me = 0; se = 0; er = 0; nk = 0; ab = 0;
        @(negedge clk);
        rst_n = 1;
        compare_all();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule